// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns one byte into an asynchronous serial character on a single output line. A one-byte holding buffer accepts a byte on a load strobe. While the sender is idle, a full buffer starts a frame on the next clock. The frame is a low start bit, eight data bits in a selectable order, a parity bit of selectable sense, and one or two high stop bits. The line rests high between frames.

The bit length in clocks, the stop-bit count, the parity sense and the bit order are runtime inputs. They are captured when a frame begins and held until it ends. Four status outputs are provided:
- `busy` is high for the whole frame.
- `buf_full` shows that the buffer holds a byte.
- `stop_phase` marks the stop bits, so a wrapper sharing a bidirectional line can use `busy & ~stop_phase` as its drive enable and turn the line around early.
- `frame_done` pulses for one clock on the final clock of the last stop bit.

If the buffer is full when a frame ends, the next frame follows with no gap.

The sequencer is a state machine with states IDLE, START, DATA, PARITY, STOP1 and STOP2. Its transitions are:
- IDLE to START when the buffer is full.
- START to DATA at the end of the start bit.
- DATA to PARITY at the end of the eighth data bit.
- PARITY to STOP1 at the end of the parity bit.
- STOP1 to STOP2 at the end of the first stop bit when two stop bits were captured.
- STOP1 or STOP2 to START at the end of the last stop bit with the buffer full.
- STOP1 or STOP2 to IDLE at the end of the last stop bit with the buffer empty.

Top module: `txs_serial_tx`

## Requirements
- R1: A high `load` while `buf_full` is low captures `load_data`, and `buf_full` is high on the next cycle. A `load` while the buffer is full and not being emptied is ignored: the held byte is unchanged.
- R2: When idle with the buffer full, a frame starts on the next clock edge. At that edge the buffer empties (`buf_full` low) and `busy` goes high. `busy` stays high until the frame ends.
- R3: A frame is a start bit at 0, then 8 data bits, then 1 parity bit, then stop bits at 1. `ser_out` is 1 whenever no frame runs.
- R4: With `msb_first`=1 the data bits go out bit 7 first, down to bit 0. With `msb_first`=0 they go out bit 0 first, up to bit 7.
- R5: With `odd_par`=1 the parity bit makes the count of ones over data plus parity odd. With `odd_par`=0 it makes that count even.
- R6: Every bit of a frame lasts `bit_clocks` clocks. A `bit_clocks` value of 0 acts as 1.
- R7: `stop_phase` is high exactly during the stop-bit clocks. `two_stop`=0 gives one stop bit and `two_stop`=1 gives two.
- R8: `frame_done` is high for exactly one clock, the final clock of the last stop bit. If the buffer is empty, `busy` is low on the following clock.
- R9: If the buffer is full when `frame_done` is high, the next start bit begins on the following clock. No idle bit comes between the two frames, and the buffer empties at that edge.
- R10: `bit_clocks`, `two_stop`, `odd_par` and `msb_first` are sampled at the edge where a frame starts. Changing them during a frame has no effect on that frame.
- R11: A `load` in the same cycle that the buffer hands its byte to a starting frame is accepted. `buf_full` stays high, and the following frame carries the new byte.
- R12: After reset, `ser_out` is 1 and `busy`, `buf_full`, `stop_phase` and `frame_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Strobe: write `load_data` into the holding buffer |
| load_data | input | 8 | Byte to send |
| bit_clocks | input | CPB_W | Clocks per bit (0 acts as 1) |
| two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| odd_par | input | 1 | 1: odd parity, 0: even parity |
| msb_first | input | 1 | 1: bit 7 first, 0: bit 0 first |
| ser_out | output | 1 | Serial line, high when idle |
| busy | output | 1 | A frame is in progress |
| buf_full | output | 1 | Holding buffer occupied |
| stop_phase | output | 1 | Stop bits being sent |
| frame_done | output | 1 | One-clock pulse on the last clock of the last stop bit |

## Verification
Two events can share one clock edge: a new `load` and the buffer handing its byte to a frame that is starting. This happens both from idle and at a `frame_done` pulse with a byte already waiting. The bench holds `load` high across the edge where a frame begins from idle. It then checks that `buf_full` is still high on the first start-bit clock and that the chained frame carries the second byte. A separate back-to-back run reloads the buffer mid-frame and checks that a further load while full is dropped and that the next start bit directly follows the end pulse.

// File: rtl/txs_pkg.sv
package txs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } txs_state_e;
endpackage

// File: rtl/txs_holdbuf.sv
module txs_holdbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] dout
);
    logic accept;

    // A byte is accepted when the slot is empty or is being emptied this cycle.
    assign accept = load && (!full || take);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            dout <= '0;
        end else begin
            if (accept) begin
                dout <= din;
                full <= 1'b1;
            end else if (take) begin
                full <= 1'b0;
            end
        end
    end

    p_full_after_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !full) |=> full);
    p_ignore_when_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load && full && !take) |=> $stable(dout));
    p_accept_on_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (load && take) |=> full);
endmodule

// File: rtl/txs_bit_timer.sv
module txs_bit_timer #(
    parameter int CPB_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             running,
    input  logic [CPB_W-1:0] bit_clocks_in,
    output logic             bit_end
);
    logic [CPB_W-1:0] len_q;
    logic [CPB_W-1:0] cnt_q;

    assign bit_end = running && (cnt_q == len_q - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= {{(CPB_W-1){1'b0}}, 1'b1};
            cnt_q <= '0;
        end else if (restart) begin
            // zero is clamped to a one-clock bit
            len_q <= (bit_clocks_in == '0) ? {{(CPB_W-1){1'b0}}, 1'b1} : bit_clocks_in;
            cnt_q <= '0;
        end else if (running) begin
            cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
        end
    end

    p_len_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !restart) |=> $stable(len_q));
    p_len_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (len_q != '0));
endmodule

// File: rtl/txs_shifter.sv
module txs_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] din,
    input  logic              msb_first_in,
    input  logic              odd_in,
    input  logic              shift,
    output logic              data_bit,
    output logic              parity_bit
);
    logic [DATA_W-1:0] sh_q;
    logic              msb_q;
    logic              par_q;

    assign data_bit   = msb_q ? sh_q[DATA_W-1] : sh_q[0];
    assign parity_bit = par_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            msb_q <= 1'b0;
            par_q <= 1'b0;
        end else if (take) begin
            sh_q  <= din;
            msb_q <= msb_first_in;
            par_q <= (^din) ^ odd_in;
        end else if (shift) begin
            if (msb_q) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
            else       sh_q <= {1'b0, sh_q[DATA_W-1:1]};
        end
    end

    p_order_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(msb_q) && $stable(par_q));
endmodule

// File: rtl/txs_sequencer.sv
module txs_sequencer
    import txs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic full,
    input  logic bit_end,
    input  logic two_stop_in,
    input  logic data_bit,
    input  logic parity_bit,
    output logic take,
    output logic shift,
    output logic running,
    output logic stop_phase,
    output logic frame_done,
    output logic ser_out
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    txs_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             two_q;
    logic             last_stop;

    assign last_stop  = (state_q == ST_STOP2) || (state_q == ST_STOP1 && !two_q);
    assign frame_done = bit_end && last_stop;
    assign take       = full && ((state_q == ST_IDLE) || frame_done);
    assign shift      = bit_end && (state_q == ST_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            two_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) begin
                two_q <= two_stop_in;
                idx_q <= '0;
            end else if (shift) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (full) state_d = ST_START;
            ST_START:  if (bit_end) state_d = ST_DATA;
            ST_DATA:   if (bit_end && idx_q == LAST_IDX) state_d = ST_PARITY;
            ST_PARITY: if (bit_end) state_d = ST_STOP1;
            ST_STOP1:  if (bit_end) state_d = two_q ? ST_STOP2 : (full ? ST_START : ST_IDLE);
            ST_STOP2:  if (bit_end) state_d = full ? ST_START : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        running    = 1'b1;
        stop_phase = 1'b0;
        ser_out    = 1'b1;
        unique case (state_q)
            ST_IDLE:   running = 1'b0;
            ST_START:  ser_out = 1'b0;
            ST_DATA:   ser_out = data_bit;
            ST_PARITY: ser_out = parity_bit;
            ST_STOP1,
            ST_STOP2:  stop_phase = 1'b1;
            default:   running = 1'b0;
        endcase
    end

    p_stop2_needs_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP2) |-> two_q);
    p_one_hot_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

// File: rtl/txs_serial_tx.sv
module txs_serial_tx #(
    parameter int CPB_W  = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [CPB_W-1:0]  bit_clocks,
    input  logic              two_stop,
    input  logic              odd_par,
    input  logic              msb_first,
    output logic              ser_out,
    output logic              busy,
    output logic              buf_full,
    output logic              stop_phase,
    output logic              frame_done
);
    logic              take;
    logic              shift;
    logic              bit_end;
    logic              data_bit;
    logic              parity_bit;
    logic [DATA_W-1:0] held;

    txs_holdbuf #(.DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .load(load), .din(load_data),
        .take(take), .full(buf_full), .dout(held)
    );

    txs_bit_timer #(.CPB_W(CPB_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(take), .running(busy),
        .bit_clocks_in(bit_clocks), .bit_end(bit_end)
    );

    txs_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .take(take), .din(held),
        .msb_first_in(msb_first), .odd_in(odd_par), .shift(shift),
        .data_bit(data_bit), .parity_bit(parity_bit)
    );

    txs_sequencer #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .full(buf_full), .bit_end(bit_end),
        .two_stop_in(two_stop), .data_bit(data_bit), .parity_bit(parity_bit),
        .take(take), .shift(shift), .running(busy), .stop_phase(stop_phase),
        .frame_done(frame_done), .ser_out(ser_out)
    );

    p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !ser_out);
    p_stop_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_phase |-> ser_out);
    p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ser_out);
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !buf_full) |=> !busy);
    p_chain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && buf_full) |=> (busy && !stop_phase && !ser_out));
    p_start_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && buf_full && !load) |=> (busy && !buf_full));
endmodule

// File: tb/txs_serial_tx_test.sv
module txs_serial_tx_test;
    localparam int CPB_W = 13;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load = 1'b0;
    logic [7:0]       load_data = '0;
    logic [CPB_W-1:0] bit_clocks = 13'd1;
    logic             two_stop = 1'b0;
    logic             odd_par = 1'b0;
    logic             msb_first = 1'b0;
    logic             ser_out, busy, buf_full, stop_phase, frame_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    txs_serial_tx #(.CPB_W(CPB_W), .DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data),
        .bit_clocks(bit_clocks), .two_stop(two_stop), .odd_par(odd_par),
        .msb_first(msb_first), .ser_out(ser_out), .busy(busy),
        .buf_full(buf_full), .stop_phase(stop_phase), .frame_done(frame_done)
    );

    // {data[14:7], msb[6], odd[5], two[4], len[3:0]}
    localparam logic [14:0] VEC [6] = '{
        {8'hA5, 1'b0, 1'b0, 1'b0, 4'd1},
        {8'h3C, 1'b1, 1'b1, 1'b1, 4'd3},
        {8'h01, 1'b1, 1'b0, 1'b0, 4'd2},
        {8'hF0, 1'b0, 1'b1, 1'b1, 4'd4},
        {8'h00, 1'b0, 1'b1, 1'b0, 4'd5},
        {8'h96, 1'b1, 1'b0, 1'b1, 4'd0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
        end
    endtask

    task automatic drive_cfg(input bit m, input bit o, input bit tw, input int len);
        msb_first  = m;
        odd_par    = o;
        two_stop   = tw;
        bit_clocks = CPB_W'(len);
    endtask

    // Entered at the negedge showing clock 0 of the start bit; returns at the
    // negedge right after the last stop-bit clock.
    task automatic check_frame(input logic [7:0] d, input bit m, input bit o, input bit tw,
                               input int len_in, input bit nm, input bit no, input bit ntw,
                               input int nlen, input int it1, input logic [7:0] id1,
                               input int it2, input logic [7:0] id2);
        int   len;
        int   nb;
        logic exp_bits [12];
        len = (len_in == 0) ? 1 : len_in;
        nb  = tw ? 12 : 11;
        exp_bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) exp_bits[1+i] = m ? d[7-i] : d[i];
        exp_bits[9]  = (^d) ^ o;
        exp_bits[10] = 1'b1;
        exp_bits[11] = 1'b1;
        for (int t = 0; t < nb*len; t++) begin
            int b;
            b = t / len;
            if (b >= 1 && b <= 8)
                chk(ser_out == exp_bits[b], m ? "R4 data bit msb-first" : "R4 data bit lsb-first",
                    ser_out, exp_bits[b]);
            else if (b == 9)
                chk(ser_out == exp_bits[b], "R5 parity bit", ser_out, exp_bits[b]);
            else
                chk(ser_out == exp_bits[b], "R3 start/stop level", ser_out, exp_bits[b]);
            chk(busy == 1'b1, "R2 busy during frame", busy, 1);
            chk(stop_phase == (b >= 10), "R7 stop phase", stop_phase, b >= 10);
            chk(frame_done == (t == nb*len-1), "R8 end pulse", frame_done, t == nb*len-1);
            if (it1 >= 0 && t == it1 + 1)
                chk(buf_full == 1'b1, "R1 load mid-frame fills buffer", buf_full, 1);
            if (t == 1) drive_cfg(nm, no, ntw, nlen); // R10 config changed mid-frame
            if (t == it1) begin
                load = 1'b1; load_data = id1;
            end else if (t == it2) begin
                load = 1'b1; load_data = id2;
            end else begin
                load = 1'b0;
            end
            @(negedge clk);
        end
        load = 1'b0;
    endtask

    task automatic check_idle(input string tag);
        chk(busy == 1'b0, tag, busy, 0);
        chk(ser_out == 1'b1, tag, ser_out, 1);
        chk(buf_full == 1'b0, tag, buf_full, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(ser_out == 1'b1, "R12 reset ser_out", ser_out, 1);
        chk(busy == 1'b0, "R12 reset busy", busy, 0);
        chk(buf_full == 1'b0, "R12 reset buf_full", buf_full, 0);
        chk(stop_phase == 1'b0, "R12 reset stop_phase", stop_phase, 0);
        chk(frame_done == 1'b0, "R12 reset frame_done", frame_done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_idle("R3 idle after reset");

        // Table of frames: R3 R4 R5 R6 R7 R8 R10
        for (int v = 0; v < 6; v++) begin
            logic [14:0] e;
            e = VEC[v];
            drive_cfg(e[6], e[5], e[4], int'(e[3:0]));
            load = 1'b1; load_data = e[14:7];
            @(negedge clk);
            load = 1'b0;
            chk(buf_full == 1'b1, "R1 load fills buffer", buf_full, 1);
            chk(busy == 1'b0, "R2 not yet started", busy, 0);
            @(negedge clk);
            chk(buf_full == 1'b0, "R2 buffer empties at start", buf_full, 0);
            check_frame(e[14:7], e[6], e[5], e[4], int'(e[3:0]),
                        ~e[6], ~e[5], ~e[4], 7, -1, 8'h00, -1, 8'h00);
            check_idle("R8 idle after end pulse");
            @(negedge clk);
        end

        // Back-to-back: R9, R1 (ignored load while full), R10
        drive_cfg(1'b0, 1'b1, 1'b0, 2);
        load = 1'b1; load_data = 8'h5A;
        @(negedge clk);
        load = 1'b0;
        @(negedge clk);
        check_frame(8'h5A, 1'b0, 1'b1, 1'b0, 2, 1'b1, 1'b0, 1'b1, 3,
                    3, 8'hC3, 6, 8'hFF);
        chk(ser_out == 1'b0, "R9 chained start bit without gap", ser_out, 0);
        chk(buf_full == 1'b0, "R9 buffer empties at chained start", buf_full, 0);
        check_frame(8'hC3, 1'b1, 1'b0, 1'b1, 3, 1'b0, 1'b0, 1'b0, 1,
                    -1, 8'h00, -1, 8'h00);
        check_idle("R1 ignored byte not sent");
        @(negedge clk);

        // Same-cycle load and take from idle: R11
        drive_cfg(1'b1, 1'b1, 1'b0, 1);
        load = 1'b1; load_data = 8'h81;
        @(negedge clk);
        load_data = 8'h7E;
        @(negedge clk);
        load = 1'b0;
        chk(buf_full == 1'b1, "R11 load on take edge kept", buf_full, 1);
        chk(ser_out == 1'b0, "R11 first frame started", ser_out, 0);
        check_frame(8'h81, 1'b1, 1'b1, 1'b0, 1, 1'b0, 1'b0, 1'b0, 2,
                    -1, 8'h00, -1, 8'h00);
        check_frame(8'h7E, 1'b0, 1'b0, 1'b0, 2, 1'b0, 1'b0, 1'b0, 2,
                    -1, 8'h00, -1, 8'h00);
        check_idle("R11 idle after second frame");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule